// File: doc/BRIEF.md
# Fast-Command Receiver with Per-Command Delay Lines

This block sits in a front-end module and turns a set of double-rate serial lines back into one fast-command word per bunch-clock cycle. Each line carries two bits per 40 MHz cycle. The block catches the first bit on the rising clock edge and the second bit on the falling edge. It then interleaves the bits into a word that holds a crossing identifier and a set of one-bit commands.

Commands reach the front end well before the crossing they refer to, typically about 16 cycles early plus cable and link time. The link itself cannot delay individual lines. Each command bit therefore goes through its own programmable delay line, from 0 to 63 cycles, and comes out as a single-cycle strobe. The crossing identifier travels with every strobe, so the consumer always sees the crossing the command belongs to. Command 0 is the reset command. When it comes out of its own delay line, it discards every command still in flight in any delay line.

Top module: `fastcmd_rx`

## Requirements
- R1: While reset is asserted and after it is released with idle lines, every strobe output `cmd_stb` is 0.
- R2: On line i, the bit sampled on the rising edge becomes word bit 2i+1, and the bit sampled on the following falling edge becomes word bit 2i. The rising-edge bit is the first bit of the cycle.
- R3: Word bits [11:0] hold the crossing identifier. Word bit 12+k is command k, for k = 0 to 7.
- R4: A command whose rising-edge bit is sampled at clock edge E pulses its strobe for exactly one cycle. The pulse starts at edge E+2+d, where d is that command's delay.
- R5: Each command k takes its own delay d from `cfg_delay[6k+5:6k]`. Delays differ freely between commands and cover the range 0 to 63.
- R6: While a command's strobe is high, its identifier output `cmd_bid[12k+11:12k]` equals the crossing identifier of the word that carried the command.
- R7: When the command-0 strobe is produced, every command that has not yet come out of its delay line is discarded. Commands that come out in that same cycle are still output. Later words are handled normally.
- R8: The same command in consecutive words gives strobes in consecutive cycles, each strobe with its own identifier.
- R9: Word bits [23:20] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch clock; both edges are used for sampling |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lines | input | 12 | Double-rate serial command lines |
| cfg_delay | input | 48 | Eight 6-bit delay values, one per command, with command k at bits [6k+5:6k] |
| cmd_stb | output | 8 | Delayed single-cycle command strobes |
| cmd_bid | output | 96 | Crossing identifier of each command's most recent strobe, with command k at bits [12k+11:12k] |

## Verification
The interesting collision is the reset command leaving its delay line in the same cycle as another command's strobe. At that moment the flush must clear what is still queued, but it must not suppress the strobe that is already emerging. The bench sets command 0 and command 2 to the same delay and sends them in one word. It has already queued command 1 with a long delay. It then expects the strobes of command 0 and command 2 together, with command 2's identifier intact, and no command-1 strobe at the cycle it was due. A later command-1 word must still come out on time.

// File: rtl/fastcmd_pkg.sv
package fastcmd_pkg;
  localparam int DEF_LINES   = 12;
  localparam int DEF_BID_W   = 12;
  localparam int DEF_NUM_CMD = 8;
  localparam int DEF_DLY_W   = 6;
  localparam int DEF_RST_CMD = 0;

  // Taps available in a delay line for a given delay field width.
  function automatic int taps_for(input int dly_w);
    return (1 << dly_w) - 1;
  endfunction
endpackage

// File: rtl/fastcmd_ddr_capture.sv
module fastcmd_ddr_capture #(
  parameter int NUM_LINES = fastcmd_pkg::DEF_LINES,
  localparam int WORD_W   = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  output logic [WORD_W-1:0]    word
);
  logic [NUM_LINES-1:0] rise_q, fall_q, rise_nxt, fall_nxt;
  logic [WORD_W-1:0]    word_q, word_nxt;
  logic [NUM_LINES-1:0] odd_bits;

  always_comb begin
    rise_nxt = lines;
    fall_nxt = lines;
  end

  // Rising-edge bit is first and more significant on each line.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_interleave
    assign word_nxt[2*i+1] = rise_q[i];
    assign word_nxt[2*i]   = fall_q[i];
    assign odd_bits[i]     = word_q[2*i+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      word_q <= '0;
    end else begin
      rise_q <= rise_nxt;
      word_q <= word_nxt;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= fall_nxt;
  end

  assign word = word_q;

  // R2: a rising-edge sample shows up in the odd word bits two edges later.
  a_r2_rise_to_odd: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (odd_bits == $past(lines, 2)));
endmodule

// File: rtl/fastcmd_delay_line.sv
module fastcmd_delay_line #(
  parameter int BID_W = fastcmd_pkg::DEF_BID_W,
  parameter int DLY_W = fastcmd_pkg::DEF_DLY_W,
  localparam int DEPTH = fastcmd_pkg::taps_for(DLY_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [DLY_W-1:0] delay,
  input  logic             in_stb,
  input  logic [BID_W-1:0] in_bid,
  output logic             emerge_stb,
  output logic             out_stb,
  output logic [BID_W-1:0] out_bid
);
  logic [DEPTH-1:0] stb_q, stb_nxt;
  logic [BID_W-1:0] bid_q   [DEPTH];
  logic [BID_W-1:0] bid_nxt [DEPTH];
  logic [DEPTH-1:0] bid_en;
  logic [DLY_W-1:0] tap;
  logic [BID_W-1:0] emerge_bid;
  logic             out_stb_q;
  logic [BID_W-1:0] out_bid_q, out_bid_nxt;

  // Shift pipeline; the identifier stage loads only when a strobe enters it.
  always_comb begin
    stb_nxt    = flush ? '0 : {stb_q[DEPTH-2:0], in_stb};
    bid_nxt[0] = in_bid;
    bid_en[0]  = in_stb;
    for (int j = 1; j < DEPTH; j++) begin
      bid_nxt[j] = bid_q[j-1];
      bid_en[j]  = stb_q[j-1];
    end
  end

  always_comb begin
    tap = delay - DLY_W'(1);
    if (delay == '0) begin
      emerge_stb = in_stb;
      emerge_bid = in_bid;
    end else begin
      emerge_stb = stb_q[tap];
      emerge_bid = bid_q[tap];
    end
    out_bid_nxt = emerge_stb ? emerge_bid : out_bid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q     <= '0;
      out_stb_q <= 1'b0;
      out_bid_q <= '0;
      for (int j = 0; j < DEPTH; j++) bid_q[j] <= '0;
    end else begin
      stb_q     <= stb_nxt;
      out_stb_q <= emerge_stb;
      out_bid_q <= out_bid_nxt;
      for (int j = 0; j < DEPTH; j++)
        if (bid_en[j]) bid_q[j] <= bid_nxt[j];
    end
  end

  assign out_stb = out_stb_q;
  assign out_bid = out_bid_q;

  // R4, R6: a zero delay gives the strobe and its identifier on the next edge.
  a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ((delay == '0) && in_stb) |=> (out_stb && (out_bid == $past(in_bid))));

  // R7: after a flush nothing remains queued.
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (stb_q == '0));
endmodule

// File: rtl/fastcmd_rx.sv
module fastcmd_rx #(
  parameter int NUM_LINES = fastcmd_pkg::DEF_LINES,
  parameter int BID_W     = fastcmd_pkg::DEF_BID_W,
  parameter int NUM_CMD   = fastcmd_pkg::DEF_NUM_CMD,
  parameter int DLY_W     = fastcmd_pkg::DEF_DLY_W,
  parameter int RST_CMD   = fastcmd_pkg::DEF_RST_CMD,
  localparam int WORD_W   = 2 * NUM_LINES,
  localparam int CMD_LSB  = BID_W,
  localparam int USED_W   = BID_W + NUM_CMD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_LINES-1:0]     lines,
  input  logic [NUM_CMD*DLY_W-1:0] cfg_delay,
  output logic [NUM_CMD-1:0]       cmd_stb,
  output logic [NUM_CMD*BID_W-1:0] cmd_bid
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [WORD_W-1:0]  word;
  logic [NUM_CMD-1:0] emerge;
  logic               flush_w;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  fastcmd_ddr_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk   (clk),
    .rst_n (rst_n_int),
    .lines (lines),
    .word  (word)
  );

  // The reset command clears every line when it emerges.
  assign flush_w = emerge[RST_CMD];

  for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd
    fastcmd_delay_line #(.BID_W(BID_W), .DLY_W(DLY_W)) u_line (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .flush      (flush_w),
      .delay      (cfg_delay[k*DLY_W +: DLY_W]),
      .in_stb     (word[CMD_LSB+k]),
      .in_bid     (word[BID_W-1:0]),
      .emerge_stb (emerge[k]),
      .out_stb    (cmd_stb[k]),
      .out_bid    (cmd_bid[k*BID_W +: BID_W])
    );
  end

  if (WORD_W > USED_W) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^word[WORD_W-1:USED_W];
  end

  // R7: a reset strobe always follows a flush of the delay lines.
  a_r7_rst_strobe_flushed: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_stb[RST_CMD] |-> $past(flush_w));
endmodule

// File: tb/fastcmd_rx_bench.sv
module fastcmd_rx_bench;
  localparam int NL = 12;
  localparam int BW = 12;
  localparam int NC = 8;
  localparam int DW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NL-1:0]     lines;
  logic [NC*DW-1:0]  cfg_delay;
  logic [NC-1:0]     cmd_stb;
  logic [NC*BW-1:0]  cmd_bid;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  fastcmd_rx u_fastcmd_rx (
    .clk(clk), .rst_n(rst_n), .lines(lines),
    .cfg_delay(cfg_delay), .cmd_stb(cmd_stb), .cmd_bid(cmd_bid)
  );

  function automatic logic [23:0] mk(input logic [3:0] spare, input logic [7:0] cmds,
                                     input logic [11:0] bid);
    return {spare, cmds, bid};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Rising-edge bits before the posedge, falling-edge bits after it.
  task automatic send(input logic [23:0] w, output int sc);
    @(negedge clk);
    #5;
    for (int i = 0; i < NL; i++) lines[i] = w[2*i+1];
    @(posedge clk);
    #5;
    for (int i = 0; i < NL; i++) lines[i] = w[2*i];
    sc = cyc;
  endtask

  task automatic idle();
    int s;
    send(24'h0, s);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic set_dly(input int k, input int d);
    cfg_delay[k*DW +: DW] = DW'(d);
  endtask

  function automatic logic [11:0] bid_of(input int k);
    return cmd_bid[k*BW +: BW];
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    lines = '0;
    cfg_delay = '0;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", 32'(cmd_stb), 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 strobes after reset", 32'(cmd_stb), 32'h0);
  endtask

  task automatic t_single();
    int s;
    cfg_delay = '0;
    send(mk(4'h0, 8'h02, 12'hABC), s);
    idle();
    wait_until(s + 1);
    check("R4 not early", 32'(cmd_stb), 32'h0);
    wait_until(s + 2);
    check("R4 strobe at E+2", 32'(cmd_stb), 32'h02);
    check("R6 R3 identifier", 32'(bid_of(1)), 32'hABC);
    wait_until(s + 3);
    check("R4 single cycle", 32'(cmd_stb), 32'h0);
  endtask

  task automatic t_order();
    int s;
    cfg_delay = '0;
    // Word bit 13 is line 6 rising; 0x555 occupies only falling-edge bits.
    send(mk(4'h0, 8'h02, 12'h555), s);
    idle();
    wait_until(s + 2);
    check("R2 rising bit -> cmd1", 32'(cmd_stb), 32'h02);
    check("R2 falling bits bid", 32'(bid_of(1)), 32'h555);
    send(mk(4'h0, 8'h01, 12'hAAA), s);
    idle();
    wait_until(s + 2);
    check("R2 falling bit -> cmd0", 32'(cmd_stb), 32'h01);
    check("R2 rising bits bid", 32'(bid_of(0)), 32'hAAA);
  endtask

  task automatic t_delays();
    int s;
    int d[8] = '{0, 1, 3, 9, 17, 30, 47, 63};
    cfg_delay = '0;
    for (int k = 1; k < NC; k++) set_dly(k, d[k]);
    send(mk(4'h0, 8'hFE, 12'h3C5), s);
    idle();
    for (int k = 1; k < NC; k++) begin
      wait_until(s + 1 + d[k]);
      check($sformatf("R5 cmd%0d not early", k), 32'(cmd_stb[k]), 32'h0);
      wait_until(s + 2 + d[k]);
      check($sformatf("R5 cmd%0d delay %0d", k, d[k]), 32'(cmd_stb), 32'(1 << k));
      check($sformatf("R6 cmd%0d bid", k), 32'(bid_of(k)), 32'h3C5);
    end
  endtask

  task automatic t_b2b();
    int s, t;
    cfg_delay = '0;
    set_dly(2, 5);
    send(mk(4'h0, 8'h04, 12'h001), s);
    send(mk(4'h0, 8'h04, 12'h002), t);
    send(mk(4'h0, 8'h04, 12'h003), t);
    idle();
    for (int n = 0; n < 3; n++) begin
      wait_until(s + 7 + n);
      check("R8 back-to-back strobe", 32'(cmd_stb), 32'h04);
      check("R8 back-to-back bid", 32'(bid_of(2)), 32'(n + 1));
    end
    wait_until(s + 10);
    check("R8 burst ends", 32'(cmd_stb), 32'h0);
  endtask

  task automatic t_rstcmd();
    int sa, sb, sc, x;
    cfg_delay = '0;
    set_dly(0, 2);
    set_dly(1, 20);
    set_dly(2, 2);
    send(mk(4'h0, 8'h02, 12'h111), sa);
    send(24'h0, x);
    send(24'h0, x);
    send(mk(4'h0, 8'h05, 12'h222), sb);
    idle();
    wait_until(sb + 4);
    check("R7 reset and coincident strobe", 32'(cmd_stb), 32'h05);
    check("R7 coincident bid kept", 32'(bid_of(2)), 32'h222);
    wait_until(sa + 22);
    check("R7 queued cmd1 dropped", 32'(cmd_stb), 32'h0);
    send(mk(4'h0, 8'h02, 12'h333), sc);
    idle();
    wait_until(sc + 22);
    check("R7 later cmd1 normal", 32'(cmd_stb), 32'h02);
    check("R7 later cmd1 bid", 32'(bid_of(1)), 32'h333);
  endtask

  task automatic t_spare();
    int s;
    cfg_delay = '0;
    send(mk(4'hF, 8'h00, 12'hFFF), s);
    idle();
    for (int n = 1; n <= 4; n++) begin
      wait_until(s + n);
      check("R9 spare bits no strobe", 32'(cmd_stb), 32'h0);
    end
    send(mk(4'hF, 8'h08, 12'h0F0), s);
    idle();
    wait_until(s + 2);
    check("R9 spare bits with cmd3", 32'(cmd_stb), 32'h08);
    check("R9 spare bits bid", 32'(bid_of(3)), 32'h0F0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_order();
    t_delays();
    t_b2b();
    t_rstcmd();
    t_spare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule